// File: doc/BRIEF.md
# Matrix remap index sequencer

This block turns a plain loop over steps 0 to VL-1 into a reordered sequence of element indices. The order comes from one 32-bit shape word. The word describes an array of up to three dimensions, and each dimension may hold any size from 1 to 64, not only powers of two. The word also selects the nesting order of the three loops and may reverse any axis. It may drop one axis from the index, which gives repeat or modulo patterns, and it may add a small constant offset to every index.

A start strobe captures the shape word and the step count. From the next cycle on, the block presents one index per cycle on a valid/ready output. It flags the final step. Once that step is taken, it either goes idle or, when a new start arrives in that same cycle, runs the next sequence with no gap. A word of all zeros gives the plain linear order. A word whose mode bits or nesting code it does not support also gives the linear order, and raises an error flag.

Top module: `matrix_remap_seq`

## Requirements
- R1: After reset, out_valid_o, last_o and err_o are 0.
- R2: A start_i with vl_i not 0 is taken when the block is idle, or in the cycle that the final step is accepted. It captures shape_i and vl_i, and step 0 is presented in the next cycle. A start_i at any other time has no effect, and a start_i with vl_i = 0 starts nothing.
- R3: A shape word of all zeros gives index = step number.
- R4: The shape word fields are: mode at bits 31:30 (0b00 means matrix); skip at 29:28; offset at 27:24; inversion at 23:21 (bit 21 is x, bit 22 is y, bit 23 is z); nesting at 20:18; z size at 17:12; y size at 11:6; x size at 5:0. Each size field holds the axis length minus 1, so the lengths are SX, SY and SZ. With no skip, index = x + SX·y + SX·SY·z + offset.
- R5: Nesting code n (innermost loop listed first): 0 gives x,y,z; 1 gives x,z,y; 2 gives y,x,z; 3 gives y,z,x; 4 gives z,x,y; 5 gives z,y,x. The innermost axis advances on every step, and an outer axis advances when the axis inside it wraps. Past SX·SY·SZ steps, all axes wrap to their start values.
- R6: When an inversion bit is set, that axis runs from its length minus 1 down to 0.
- R7: Skip code 1 drops x, so index = y + SY·z + offset. Code 2 drops y, so index = x + SX·z + offset. Code 3 drops z, so index = x + SX·y + offset.
- R8: A step advances only when out_valid_o and out_ready_i are both 1. While out_ready_i is 0, idx_o and last_o hold their values.
- R9: last_o is 1 on step VL-1 only. Once that step is accepted, out_valid_o falls, unless R2 restarts the block in that cycle.
- R10: A shape word with mode bits that are not 0b00, or with nesting code 6 or 7, gives index = step number, and err_o is 1 while out_valid_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| shape_i | input | 32 | Shape word, captured on start |
| vl_i | input | 7 | Number of steps, captured on start |
| out_ready_i | input | 1 | Consumer accepts the current index |
| out_valid_o | output | 1 | An index is presented |
| idx_o | output | 19 | Remapped element index |
| last_o | output | 1 | Current step is VL-1 |
| err_o | output | 1 | Shape word is not a supported matrix mode |

## Verification
Two of this block's functions can fall in the same cycle: the final step of one sequence is accepted, and a start strobe for the next sequence arrives. The bench asserts start while the last step of a 3-step run is being accepted. It then checks that the next cycle already shows step 0 of a new, transposed shape, and follows that sequence to its end. A second case raises start in the middle of a run. There the bench checks that the original sequence carries on unchanged, which shows that the strobe is taken only at the end of a run.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int WORD_W = 32;
    localparam int DIM_W  = 6;
    localparam int OFF_W  = 4;
    localparam int NAX    = 3;
    localparam int VL_W   = 7;
    localparam int AX_W   = 2;
    localparam int IDX_W  = NAX * DIM_W + 1;

    typedef logic [AX_W-1:0] axis_t;
    localparam axis_t AX_X = 2'd0;
    localparam axis_t AX_Y = 2'd1;
    localparam axis_t AX_Z = 2'd2;

    typedef enum logic [1:0] {SK_NONE = 2'd0, SK_X = 2'd1, SK_Y = 2'd2, SK_Z = 2'd3} skip_e;

    typedef struct packed {
        logic [1:0]       mode;
        logic [1:0]       skip;
        logic [OFF_W-1:0] offset;
        logic [2:0]       inv;
        logic [2:0]       nest;
        logic [DIM_W-1:0] zd;
        logic [DIM_W-1:0] yd;
        logic [DIM_W-1:0] xd;
    } shape_t;

    typedef logic [NAX-1:0][DIM_W-1:0] dims_t;
    typedef logic [NAX-1:0][AX_W-1:0]  order_t;

    // element 0 is the innermost loop
    function automatic order_t nest_order(input logic [2:0] code);
        order_t o;
        case (code)
            3'd1:    begin o[0] = AX_X; o[1] = AX_Z; o[2] = AX_Y; end
            3'd2:    begin o[0] = AX_Y; o[1] = AX_X; o[2] = AX_Z; end
            3'd3:    begin o[0] = AX_Y; o[1] = AX_Z; o[2] = AX_X; end
            3'd4:    begin o[0] = AX_Z; o[1] = AX_X; o[2] = AX_Y; end
            3'd5:    begin o[0] = AX_Z; o[1] = AX_Y; o[2] = AX_X; end
            default: begin o[0] = AX_X; o[1] = AX_Y; o[2] = AX_Z; end
        endcase
        return o;
    endfunction
endpackage

// File: rtl/remap_shape_dec.sv
module remap_shape_dec
    import remap_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output dims_t             dmax_o,
    output order_t            order_o,
    output logic [2:0]        inv_o,
    output skip_e             skip_o,
    output logic [OFF_W-1:0]  offset_o,
    output logic              ident_o,
    output logic              bad_o
);
    shape_t sh;
    logic   unsupported;

    always_comb begin
        sh          = shape_t'(word_i);
        unsupported = (sh.mode != 2'b00) || (sh.nest > 3'd5);
        bad_o       = unsupported;
        ident_o     = unsupported || (word_i == '0);
        dmax_o[AX_X] = sh.xd;
        dmax_o[AX_Y] = sh.yd;
        dmax_o[AX_Z] = sh.zd;
        order_o     = nest_order(sh.nest);
        inv_o       = sh.inv;
        skip_o      = skip_e'(sh.skip);
        offset_o    = sh.offset;
    end
endmodule

// File: rtl/remap_axis_ctr.sv
module remap_axis_ctr
    import remap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear_i,
    input  logic   adv_i,
    input  dims_t  dmax_i,
    input  order_t order_i,
    output dims_t  cnt_o
);
    dims_t cnt_q;
    dims_t cnt_d;
    logic  carry;

    always_comb begin
        cnt_d = cnt_q;
        carry = adv_i;
        for (int p = 0; p < NAX; p++) begin
            if (carry) begin
                if (cnt_q[order_i[p]] == dmax_i[order_i[p]]) begin
                    cnt_d[order_i[p]] = '0;
                end else begin
                    cnt_d[order_i[p]] = DIM_W'(cnt_q[order_i[p]] + 1'b1);
                    carry = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) cnt_q <= '0;
        else                cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    generate
        for (genvar a = 0; a < NAX; a++) begin : g_rng
            // R5
            axis_in_range_chk: assert property (@(posedge clk) disable iff (rst)
                !clear_i |=> cnt_q[a] <= dmax_i[a]);
        end
    endgenerate
endmodule

// File: rtl/remap_idx_calc.sv
module remap_idx_calc
    import remap_pkg::*;
(
    input  dims_t            cnt_i,
    input  dims_t            dmax_i,
    input  logic [2:0]       inv_i,
    input  skip_e            skip_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic             ident_i,
    input  logic [VL_W-1:0]  step_i,
    output logic [IDX_W-1:0] idx_o
);
    dims_t            coord;
    logic [IDX_W-1:0] len [NAX];
    logic [IDX_W-1:0] wt  [NAX];
    logic [IDX_W-1:0] acc;

    generate
        for (genvar a = 0; a < NAX; a++) begin : g_ax
            assign coord[a] = inv_i[a] ? DIM_W'(dmax_i[a] - cnt_i[a]) : cnt_i[a];
            assign len[a]   = IDX_W'(dmax_i[a]) + IDX_W'(1);
        end
    endgenerate

    always_comb begin
        case (skip_i)
            SK_X:    begin wt[0] = '0;        wt[1] = IDX_W'(1); wt[2] = len[1]; end
            SK_Y:    begin wt[0] = IDX_W'(1); wt[1] = '0;        wt[2] = len[0]; end
            SK_Z:    begin wt[0] = IDX_W'(1); wt[1] = len[0];    wt[2] = '0;     end
            default: begin wt[0] = IDX_W'(1); wt[1] = len[0];    wt[2] = IDX_W'(len[0] * len[1]); end
        endcase
        acc = IDX_W'(offset_i);
        for (int a = 0; a < NAX; a++) begin
            acc = IDX_W'(acc + IDX_W'(IDX_W'(coord[a]) * wt[a]));
        end
        idx_o = ident_i ? IDX_W'(step_i) : acc;
    end
endmodule

// File: rtl/matrix_remap_seq.sv
module matrix_remap_seq
    import remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] shape_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              last_o,
    output logic              err_o
);
    dims_t            dmax_d, dmax_q;
    order_t           order_d, order_q;
    logic [2:0]       inv_d, inv_q;
    skip_e            skip_d, skip_q;
    logic [OFF_W-1:0] off_d, off_q;
    logic             ident_d, ident_q;
    logic             bad_d, bad_q;

    logic             busy_q;
    logic [VL_W-1:0]  step_q;
    logic [VL_W-1:0]  vl_q;
    logic             fire, at_last, accept;
    dims_t            cnt;

    remap_shape_dec u_dec (
        .word_i   (shape_i),
        .dmax_o   (dmax_d),
        .order_o  (order_d),
        .inv_o    (inv_d),
        .skip_o   (skip_d),
        .offset_o (off_d),
        .ident_o  (ident_d),
        .bad_o    (bad_d)
    );

    assign fire    = busy_q && out_ready_i;
    assign at_last = (step_q == VL_W'(vl_q - 1'b1));
    assign accept  = start_i && (vl_i != '0) && (!busy_q || (fire && at_last));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            step_q  <= '0;
            vl_q    <= '0;
            dmax_q  <= '0;
            order_q <= '0;
            inv_q   <= '0;
            skip_q  <= SK_NONE;
            off_q   <= '0;
            ident_q <= 1'b0;
            bad_q   <= 1'b0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            step_q  <= '0;
            vl_q    <= vl_i;
            dmax_q  <= dmax_d;
            order_q <= order_d;
            inv_q   <= inv_d;
            skip_q  <= skip_d;
            off_q   <= off_d;
            ident_q <= ident_d;
            bad_q   <= bad_d;
        end else if (fire) begin
            if (at_last) busy_q <= 1'b0;
            else         step_q <= VL_W'(step_q + 1'b1);
        end
    end

    remap_axis_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .adv_i   (fire && !at_last),
        .dmax_i  (dmax_q),
        .order_i (order_q),
        .cnt_o   (cnt)
    );

    remap_idx_calc u_calc (
        .cnt_i    (cnt),
        .dmax_i   (dmax_q),
        .inv_i    (inv_q),
        .skip_i   (skip_q),
        .offset_i (off_q),
        .ident_i  (ident_q),
        .step_i   (step_q),
        .idx_o    (idx_o)
    );

    assign out_valid_o = busy_q;
    assign last_o      = busy_q && at_last;
    assign err_o       = busy_q && bad_q;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(idx_o) && $stable(last_o));
    // R9
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> out_valid_o);
    // R9
    drop_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && out_ready_i && last_o && !start_i |=> !out_valid_o);
    // R2
    restart_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && out_ready_i && last_o && start_i && (vl_i != '0) |=> out_valid_o);
    // R10
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> out_valid_o);
    // R3
    identity_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && ident_q |-> idx_o == IDX_W'(step_q));
endmodule

// File: tb/matrix_remap_seq_tb.sv
module matrix_remap_seq_tb;
    localparam int NROW = 11;
    localparam logic [31:0] T_SHAPE [NROW] = '{
        32'h00000000, 32'h00000042, 32'h00080042, 32'h10000082, 32'h00200042, 32'h05141041,
        32'h00000002, 32'h40000042, 32'h0000003F, 32'h30802001, 32'h001C0042};
    localparam int T_VL   [NROW] = '{5, 6, 6, 9, 6, 8, 7, 4, 127, 6, 3};
    localparam int T_STEP [NROW] = '{4, 4, 4, 4, 0, 1, 6, 3, 100, 3, 2};
    localparam int T_IDX  [NROW] = '{4, 4, 2, 1, 2, 9, 0, 3, 36, 1, 2};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] shape_i = '0;
    logic [6:0]  vl_i = '0;
    logic        out_ready_i = 1'b0;
    logic        out_valid_o;
    logic [18:0] idx_o;
    logic        last_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    matrix_remap_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .shape_i(shape_i), .vl_i(vl_i),
        .out_ready_i(out_ready_i), .out_valid_o(out_valid_o), .idx_o(idx_o),
        .last_o(last_o), .err_o(err_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic string row_req(input int r);
        case (r)
            0: return "R3";
            2, 5, 6: return "R5";
            3, 9: return "R7";
            4: return "R6";
            7, 10: return "R10";
            default: return "R4";
        endcase
    endfunction

    function automatic bit is_bad(input logic [31:0] w);
        return (w[31:30] != 2'b00) || (w[20:18] > 3'd5);
    endfunction

    function automatic int model(input logic [31:0] w, input int i);
        int s [3];
        int c [3];
        int o [3];
        int t;
        int r;
        if (w == 0 || is_bad(w)) return i;
        s[0] = int'(w[5:0]) + 1;
        s[1] = int'(w[11:6]) + 1;
        s[2] = int'(w[17:12]) + 1;
        case (w[20:18])
            3'd1: begin o[0] = 0; o[1] = 2; o[2] = 1; end
            3'd2: begin o[0] = 1; o[1] = 0; o[2] = 2; end
            3'd3: begin o[0] = 1; o[1] = 2; o[2] = 0; end
            3'd4: begin o[0] = 2; o[1] = 0; o[2] = 1; end
            3'd5: begin o[0] = 2; o[1] = 1; o[2] = 0; end
            default: begin o[0] = 0; o[1] = 1; o[2] = 2; end
        endcase
        t = i;
        for (int p = 0; p < 3; p++) begin
            c[o[p]] = t % s[o[p]];
            t = t / s[o[p]];
        end
        for (int a = 0; a < 3; a++) if (w[21 + a]) c[a] = s[a] - 1 - c[a];
        case (w[29:28])
            2'd1: r = c[1] + s[1] * c[2];
            2'd2: r = c[0] + s[0] * c[2];
            2'd3: r = c[0] + s[0] * c[1];
            default: r = c[0] + s[0] * c[1] + s[0] * s[1] * c[2];
        endcase
        return r + int'(w[27:24]);
    endfunction

    // checks one presented step at a negedge
    task automatic see_step(input logic [31:0] w, input int vl, input int i);
        chk(out_valid_o == 1'b1, "R8 valid", int'(out_valid_o), 1);
        chk(int'(idx_o) == model(w, i), "R4 index", int'(idx_o), model(w, i));
        chk(last_o == (i == vl - 1), "R9 last", int'(last_o), int'(i == vl - 1));
        chk(err_o == is_bad(w), "R10 err", int'(err_o), int'(is_bad(w)));
    endtask

    task automatic launch(input logic [31:0] w, input int vl);
        shape_i = w;
        vl_i    = 7'(vl);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(out_valid_o == 1'b0, "R1 valid", int'(out_valid_o), 0);
        chk(last_o == 1'b0, "R1 last", int'(last_o), 0);
        chk(err_o == 1'b0, "R1 err", int'(err_o), 0);

        // table walk
        out_ready_i = 1'b1;
        for (int r = 0; r < NROW; r++) begin
            launch(T_SHAPE[r], T_VL[r]);
            for (int i = 0; i < T_VL[r]; i++) begin
                see_step(T_SHAPE[r], T_VL[r], i);
                if (i == T_STEP[r]) chk(int'(idx_o) == T_IDX[r], row_req(r), int'(idx_o), T_IDX[r]);
                @(negedge clk);
            end
            chk(out_valid_o == 1'b0, "R9 idle after last", int'(out_valid_o), 0);
        end

        // R2: zero step count starts nothing
        launch(32'h00000042, 0);
        chk(out_valid_o == 1'b0, "R2 vl zero", int'(out_valid_o), 0);

        // R8: stall holds index
        out_ready_i = 1'b0;
        launch(32'h00000042, 6);
        for (int k = 0; k < 3; k++) begin
            chk(out_valid_o && idx_o == 19'd0, "R8 stall", int'(idx_o), 0);
            @(negedge clk);
        end
        out_ready_i = 1'b1;
        see_step(32'h00000042, 6, 0);
        @(negedge clk);
        see_step(32'h00000042, 6, 1);
        chk(int'(idx_o) == 1, "R8 resume", int'(idx_o), 1);
        for (int i = 2; i < 6; i++) begin
            @(negedge clk);
            see_step(32'h00000042, 6, i);
        end
        @(negedge clk);

        // R2: start mid-run is ignored
        launch(32'h00080042, 6);
        for (int i = 0; i < 6; i++) begin
            see_step(32'h00080042, 6, i);
            if (i == 2) begin
                shape_i = 32'h0;
                vl_i    = 7'd3;
                start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        chk(out_valid_o == 1'b0, "R2 busy start ignored", int'(out_valid_o), 0);

        // R2 and R9: restart in the cycle of the final accept
        launch(32'h00000042, 3);
        see_step(32'h00000042, 3, 0);
        @(negedge clk);
        see_step(32'h00000042, 3, 1);
        @(negedge clk);
        see_step(32'h00000042, 3, 2);
        shape_i = 32'h00080042;
        vl_i    = 7'd4;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(out_valid_o == 1'b1, "R2 back to back", int'(out_valid_o), 1);
        for (int i = 0; i < 4; i++) begin
            see_step(32'h00080042, 4, i);
            if (i == 1) chk(int'(idx_o) == 3, "R5 restart transposed", int'(idx_o), 3);
            @(negedge clk);
        end
        chk(out_valid_o == 1'b0, "R9 end of restart", int'(out_valid_o), 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule